// File: doc/BRIEF.md
# Segment Address Translation Front End

This block decides, for every 32-bit virtual address a core issues, which of three translation routes applies. When the global configuration leaves translation switched off, the address goes through unchanged with every permission granted. When translation is on and a privileged access falls in a segment marked for direct mapping, the top nibble of the address is swapped for a 4-bit base taken from one of two packed kernel-base registers. Every other access is handed to a page TLB over a valid/ready request port, and the TLB's reply is passed back.

Requests are taken with a valid/ready handshake. The address, the user flag and all four configuration words are taken in the cycle the request is accepted; later changes on those inputs do not affect a request already taken. Results come back as a one-cycle `done` pulse carrying the physical address, a read/write/execute permission vector and a miss flag.

Top module: `seg_xlate_front`

## Requirements
- R1: After reset, `done` and `tlb_req_valid` are 0 and `req_ready` is 1.
- R2: Translation is on when `cfg_global` bit 2 or bit 3 is 1. When it is off, the result is `paddr` = `req_vaddr`, `perm` = 3'b111 and `miss` = 0, whatever `cfg_mmu` and `req_user` hold.
- R3: With translation on, the segment number is `req_vaddr[31:28]`. The direct segment route is taken only when bit <segment> of `cfg_mmu` is 1 and `req_user` is 0. A user access never takes it.
- R4: Segments 0 to 7 take their base from `kbase_lo`, and segments 8 to 15 from `kbase_hi`. The base is bits [4*(seg mod 8)+3 : 4*(seg mod 8)] of the chosen register.
- R5: A directly mapped result is {base, `req_vaddr[27:0]`}, with `perm` = 3'b111 and `miss` = 0.
- R6: Any other access with translation on raises `tlb_req_valid` with `tlb_req_vaddr` = `req_vaddr` and `tlb_req_user` = `req_user`. The TLB's `tlb_rsp_paddr`, `tlb_rsp_perm` (bit 0 read, bit 1 write, bit 2 execute) and `tlb_rsp_miss` are returned unchanged.
- R7: On the pass-through and segment routes, `done` is 1 in the cycle right after the accepting edge and is a single-cycle pulse. A new request may be accepted in the same cycle that `done` shows the previous result.
- R8: `tlb_req_valid` and `tlb_req_vaddr` hold until `tlb_req_ready` is seen. `done` rises in the cycle after the first `tlb_rsp_valid` that follows that handshake.
- R9: While a request is outstanding, `req_ready` is 0 and changes on the request and configuration inputs have no effect on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_user | input | 1 | Access made in user mode |
| cfg_global | input | 32 | Global configuration; bits 2 and 3 switch translation on |
| cfg_mmu | input | 32 | Bits 15:0 mark segments for direct mapping |
| kbase_lo | input | 32 | Packed base nibbles for segments 0 to 7 |
| kbase_hi | input | 32 | Packed base nibbles for segments 8 to 15 |
| tlb_req_valid | output | 1 | Page lookup request |
| tlb_req_ready | input | 1 | TLB takes the lookup |
| tlb_req_vaddr | output | 32 | Address sent for lookup |
| tlb_req_user | output | 1 | User flag sent for lookup |
| tlb_rsp_valid | input | 1 | TLB result present |
| tlb_rsp_paddr | input | 32 | TLB physical address |
| tlb_rsp_perm | input | 3 | TLB permissions {exec, write, read} |
| tlb_rsp_miss | input | 1 | TLB miss or protection fault |
| done | output | 1 | Result pulse |
| paddr | output | 32 | Physical address |
| perm | output | 3 | Permissions {exec, write, read} |
| miss | output | 1 | Translation failed |

## Verification
The result pulse of one request and the acceptance of the next can fall in the same cycle. The bench drives a new request at the very falling edge where it checks the previous `done`, so the two overlap whenever transactions run back to back. It then checks that the new result replaces the old one exactly one edge later, and that `done` drops when a gap is left. A TLB response arriving while configuration inputs are being scrambled is judged the same way: the returned values must match the response and the acceptance-time route.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   localparam int PERM_W = 3;
   typedef logic [PERM_W-1:0] perm_t;
   localparam perm_t PERM_ALL = '1;

   typedef enum logic [1:0] {
      PATH_PASS = 2'd0,
      PATH_SEG  = 2'd1,
      PATH_PAGE = 2'd2
   } path_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } seq_state_e;

endpackage

// File: rtl/seg_base_select.sv
module seg_base_select #(
   parameter int SEG_W    = 4,
   parameter int BASE_MUX = 0,
   parameter int KB_W     = ((1 << SEG_W) / 2) * SEG_W
) (
   input  logic [SEG_W-1:0] seg,
   input  logic [KB_W-1:0]  kbase_lo,
   input  logic [KB_W-1:0]  kbase_hi,
   output logic [SEG_W-1:0] base
);
   localparam int NSEG = 1 << SEG_W;
   localparam int HALF = NSEG / 2;

   logic [SEG_W-1:0] nib [NSEG];

   // unpack both registers into one table: low register fills the first half
   for (genvar g = 0; g < HALF; g++) begin : g_unpack
      assign nib[g]        = kbase_lo[g*SEG_W +: SEG_W];
      assign nib[g + HALF] = kbase_hi[g*SEG_W +: SEG_W];
   end

   if (BASE_MUX == 0) begin : g_index
      assign base = nib[seg];
   end else begin : g_andor
      always_comb begin
         base = '0;
         for (int i = 0; i < NSEG; i++) begin
            if (seg == SEG_W'(i)) begin
               base = base | nib[i];
            end
         end
      end
   end

endmodule

// File: rtl/seg_path_decode.sv
module seg_path_decode
   import seg_xlate_pkg::*;
#(
   parameter int              ADDR_W   = 32,
   parameter int              SEG_W    = 4,
   parameter int              CFG_W    = 32,
   parameter logic [CFG_W-1:0] EN_MASK = 'hC,
   parameter int              BASE_MUX = 0,
   parameter int              KB_W     = ((1 << SEG_W) / 2) * SEG_W
) (
   input  logic [ADDR_W-1:0] vaddr,
   input  logic              user,
   input  logic [CFG_W-1:0]  gcfg,
   input  logic [CFG_W-1:0]  mcfg,
   input  logic [KB_W-1:0]   kbase_lo,
   input  logic [KB_W-1:0]   kbase_hi,
   output path_e             path,
   output logic [ADDR_W-1:0] direct_paddr
);
   localparam int NSEG  = 1 << SEG_W;
   localparam int OFF_W = ADDR_W - SEG_W;

   logic [SEG_W-1:0] seg;
   logic [NSEG-1:0]  seg_mask;
   logic [SEG_W-1:0] base;
   logic             xlate_on;
   logic             seg_mapped;

   assign seg      = vaddr[ADDR_W-1 -: SEG_W];
   assign seg_mask = mcfg[NSEG-1:0];

   if (CFG_W > NSEG) begin : g_spare
      logic unused_mcfg_hi;
      assign unused_mcfg_hi = ^mcfg[CFG_W-1:NSEG];
   end

   assign xlate_on   = |(gcfg & EN_MASK);
   assign seg_mapped = seg_mask[seg] & ~user;

   seg_base_select #(
      .SEG_W   (SEG_W),
      .BASE_MUX(BASE_MUX),
      .KB_W    (KB_W)
   ) i_base (
      .seg     (seg),
      .kbase_lo(kbase_lo),
      .kbase_hi(kbase_hi),
      .base    (base)
   );

   always_comb begin
      if (!xlate_on) begin
         path         = PATH_PASS;
         direct_paddr = vaddr;
      end else if (seg_mapped) begin
         path         = PATH_SEG;
         direct_paddr = {base, vaddr[OFF_W-1:0]};
      end else begin
         path         = PATH_PAGE;
         direct_paddr = vaddr;
      end
   end

endmodule

// File: rtl/seg_tlb_sequencer.sv
module seg_tlb_sequencer
   import seg_xlate_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_vaddr,
   input  logic              req_user,
   input  path_e             path,
   input  logic [ADDR_W-1:0] direct_paddr,
   output logic              tlb_req_valid,
   input  logic              tlb_req_ready,
   output logic [ADDR_W-1:0] tlb_req_vaddr,
   output logic              tlb_req_user,
   input  logic              tlb_rsp_valid,
   input  logic [ADDR_W-1:0] tlb_rsp_paddr,
   input  perm_t             tlb_rsp_perm,
   input  logic              tlb_rsp_miss,
   output logic              done,
   output logic [ADDR_W-1:0] paddr,
   output perm_t             perm,
   output logic              miss
);
   seq_state_e        state_q;
   logic [ADDR_W-1:0] vaddr_q;
   logic              user_q;
   logic              done_q;
   logic [ADDR_W-1:0] paddr_q;
   perm_t             perm_q;
   logic              miss_q;
   path_e             done_path_q;
   logic              req_fire;

   assign req_ready = (state_q == ST_IDLE);
   assign req_fire  = req_valid & req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         vaddr_q     <= '0;
         user_q      <= 1'b0;
         done_q      <= 1'b0;
         paddr_q     <= '0;
         perm_q      <= '0;
         miss_q      <= 1'b0;
         done_path_q <= PATH_PASS;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_fire) begin
                  if (path == PATH_PAGE) begin
                     vaddr_q <= req_vaddr;
                     user_q  <= req_user;
                     state_q <= ST_ISSUE;
                  end else begin
                     done_q      <= 1'b1;
                     paddr_q     <= direct_paddr;
                     perm_q      <= PERM_ALL;
                     miss_q      <= 1'b0;
                     done_path_q <= path;
                  end
               end
            end
            ST_ISSUE: begin
               if (tlb_req_ready) begin
                  state_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (tlb_rsp_valid) begin
                  done_q      <= 1'b1;
                  paddr_q     <= tlb_rsp_paddr;
                  perm_q      <= tlb_rsp_perm;
                  miss_q      <= tlb_rsp_miss;
                  done_path_q <= PATH_PAGE;
                  state_q     <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign tlb_req_valid = (state_q == ST_ISSUE);
   assign tlb_req_vaddr = vaddr_q;
   assign tlb_req_user  = user_q;
   assign done          = done_q;
   assign paddr         = paddr_q;
   assign perm          = perm_q;
   assign miss          = miss_q;

   p_direct_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_fire && (path != PATH_PAGE) |=> done && !miss && (perm == PERM_ALL));

   p_seg_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done && (done_path_q == PATH_SEG) |-> !miss && (perm == PERM_ALL));

   p_tlb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_req_valid && !tlb_req_ready |=> tlb_req_valid && $stable(tlb_req_vaddr));

   p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_req_valid |-> !req_ready && !done);

   p_rsp_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT) && tlb_rsp_valid |=>
         done && (paddr == $past(tlb_rsp_paddr)) && (miss == $past(tlb_rsp_miss))
         && (perm == $past(tlb_rsp_perm)));

endmodule

// File: rtl/seg_xlate_front.sv
module seg_xlate_front
   import seg_xlate_pkg::*;
#(
   parameter int               ADDR_W   = 32,
   parameter int               SEG_W    = 4,
   parameter int               CFG_W    = 32,
   parameter logic [CFG_W-1:0] EN_MASK  = 'hC,
   parameter int               BASE_MUX = 0,
   parameter int               KB_W     = ((1 << SEG_W) / 2) * SEG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_vaddr,
   input  logic              req_user,
   input  logic [CFG_W-1:0]  cfg_global,
   input  logic [CFG_W-1:0]  cfg_mmu,
   input  logic [KB_W-1:0]   kbase_lo,
   input  logic [KB_W-1:0]   kbase_hi,
   output logic              tlb_req_valid,
   input  logic              tlb_req_ready,
   output logic [ADDR_W-1:0] tlb_req_vaddr,
   output logic              tlb_req_user,
   input  logic              tlb_rsp_valid,
   input  logic [ADDR_W-1:0] tlb_rsp_paddr,
   input  logic [2:0]        tlb_rsp_perm,
   input  logic              tlb_rsp_miss,
   output logic              done,
   output logic [ADDR_W-1:0] paddr,
   output logic [2:0]        perm,
   output logic              miss
);
   localparam int NSEG = 1 << SEG_W;

   if (SEG_W < 2) begin : g_chk_seg
      $error("seg_xlate_front: SEG_W must be at least 2");
   end
   if (ADDR_W <= SEG_W) begin : g_chk_addr
      $error("seg_xlate_front: ADDR_W must exceed SEG_W");
   end
   if (CFG_W < NSEG) begin : g_chk_cfg
      $error("seg_xlate_front: CFG_W too narrow for the segment mask");
   end
   if (KB_W != (NSEG / 2) * SEG_W) begin : g_chk_kb
      $error("seg_xlate_front: KB_W must hold half the segment bases");
   end
   if (PERM_W != 3) begin : g_chk_perm
      $error("seg_xlate_front: permission vector must be 3 bits");
   end

   path_e             path;
   logic [ADDR_W-1:0] direct_paddr;
   perm_t             perm_int;

   seg_path_decode #(
      .ADDR_W  (ADDR_W),
      .SEG_W   (SEG_W),
      .CFG_W   (CFG_W),
      .EN_MASK (EN_MASK),
      .BASE_MUX(BASE_MUX),
      .KB_W    (KB_W)
   ) i_decode (
      .vaddr       (req_vaddr),
      .user        (req_user),
      .gcfg        (cfg_global),
      .mcfg        (cfg_mmu),
      .kbase_lo    (kbase_lo),
      .kbase_hi    (kbase_hi),
      .path        (path),
      .direct_paddr(direct_paddr)
   );

   seg_tlb_sequencer #(
      .ADDR_W(ADDR_W)
   ) i_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_vaddr    (req_vaddr),
      .req_user     (req_user),
      .path         (path),
      .direct_paddr (direct_paddr),
      .tlb_req_valid(tlb_req_valid),
      .tlb_req_ready(tlb_req_ready),
      .tlb_req_vaddr(tlb_req_vaddr),
      .tlb_req_user (tlb_req_user),
      .tlb_rsp_valid(tlb_rsp_valid),
      .tlb_rsp_paddr(tlb_rsp_paddr),
      .tlb_rsp_perm (perm_t'(tlb_rsp_perm)),
      .tlb_rsp_miss (tlb_rsp_miss),
      .done         (done),
      .paddr        (paddr),
      .perm         (perm_int),
      .miss         (miss)
   );

   assign perm = perm_int;

   p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> req_ready && !done && !tlb_req_valid);

endmodule

// File: tb/test_seg_xlate_front.sv
module test_seg_xlate_front;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        req_user = 1'b0;
   logic [31:0] cfg_global = '0;
   logic [31:0] cfg_mmu = '0;
   logic [31:0] kbase_lo = '0;
   logic [31:0] kbase_hi = '0;
   logic        tlb_req_valid;
   logic        tlb_req_ready = 1'b0;
   logic [31:0] tlb_req_vaddr;
   logic        tlb_req_user;
   logic        tlb_rsp_valid = 1'b0;
   logic [31:0] tlb_rsp_paddr = '0;
   logic [2:0]  tlb_rsp_perm = '0;
   logic        tlb_rsp_miss = 1'b0;
   logic        done;
   logic [31:0] paddr;
   logic [2:0]  perm;
   logic        miss;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   seg_xlate_front i_seg_xlate_front (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_user(req_user),
      .cfg_global(cfg_global), .cfg_mmu(cfg_mmu),
      .kbase_lo(kbase_lo), .kbase_hi(kbase_hi),
      .tlb_req_valid(tlb_req_valid), .tlb_req_ready(tlb_req_ready),
      .tlb_req_vaddr(tlb_req_vaddr), .tlb_req_user(tlb_req_user),
      .tlb_rsp_valid(tlb_rsp_valid), .tlb_rsp_paddr(tlb_rsp_paddr),
      .tlb_rsp_perm(tlb_rsp_perm), .tlb_rsp_miss(tlb_rsp_miss),
      .done(done), .paddr(paddr), .perm(perm), .miss(miss)
   );

   task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
      end
   endtask

   // route: 0 pass-through, 1 segment, 2 page
   function automatic int exp_route(input logic [31:0] va, input logic usr,
                                    input logic [31:0] g, input logic [31:0] m);
      int s;
      s = int'(va >> 28);
      if (g[2] == 1'b0 && g[3] == 1'b0) return 0;
      if (((m >> s) & 32'd1) == 32'd1 && !usr) return 1;
      return 2;
   endfunction

   function automatic logic [31:0] exp_seg_addr(input logic [31:0] va,
                                               input logic [31:0] lo,
                                               input logic [31:0] hi);
      int s;
      logic [31:0] src;
      logic [31:0] nibv;
      s = int'(va >> 28);
      src = (s < 8) ? lo : hi;
      nibv = (src >> (4 * (s % 8))) & 32'hF;
      return (nibv << 28) | (va & 32'h0FFF_FFFF);
   endfunction

   // entered and left at a falling edge
   task automatic run(input logic [31:0] va, input logic usr,
                      input logic [31:0] g, input logic [31:0] m,
                      input logic [31:0] lo, input logic [31:0] hi,
                      input int d_rdy, input int d_rsp,
                      input logic [31:0] r_pa, input logic [2:0] r_pm,
                      input logic r_ms);
      int rt;
      logic [31:0] ea;
      rt = exp_route(va, usr, g, m);
      ea = (rt == 1) ? exp_seg_addr(va, lo, hi) : va;
      chk(req_ready == 1'b1, "R9 ready before request", 32'(req_ready), 32'd1);
      req_valid = 1'b1; req_vaddr = va; req_user = usr;
      cfg_global = g; cfg_mmu = m; kbase_lo = lo; kbase_hi = hi;
      @(negedge clk);
      req_valid = 1'b0;
      // R9: scramble every request and configuration input after acceptance
      req_vaddr = ~va; req_user = ~usr; cfg_global = ~g; cfg_mmu = ~m;
      kbase_lo = ~lo; kbase_hi = ~hi;
      if (rt != 2) begin
         chk(done == 1'b1, "R7 done one cycle after accept", 32'(done), 32'd1);
         chk(paddr == ea, (rt == 0) ? "R2 pass-through address" : "R4 R5 segment address",
             paddr, ea);
         chk(perm == 3'b111, "R5 full permissions", 32'(perm), 32'd7);
         chk(miss == 1'b0, "R2 R5 no miss", 32'(miss), 32'd0);
         chk(tlb_req_valid == 1'b0, "R3 no lookup on direct route", 32'(tlb_req_valid), 32'd0);
      end else begin
         chk(done == 1'b0, "R8 no early done", 32'(done), 32'd0);
         chk(tlb_req_valid == 1'b1, "R6 lookup raised", 32'(tlb_req_valid), 32'd1);
         chk(tlb_req_vaddr == va, "R6 lookup address", tlb_req_vaddr, va);
         chk(tlb_req_user == usr, "R6 lookup user flag", 32'(tlb_req_user), 32'(usr));
         for (int k = 0; k < d_rdy; k++) begin
            @(negedge clk);
            chk(tlb_req_valid == 1'b1 && tlb_req_vaddr == va, "R8 lookup held",
                tlb_req_vaddr, va);
         end
         tlb_req_ready = 1'b1;
         @(negedge clk);
         tlb_req_ready = 1'b0;
         chk(tlb_req_valid == 1'b0, "R8 lookup dropped after ready", 32'(tlb_req_valid), 32'd0);
         chk(req_ready == 1'b0, "R9 busy while waiting", 32'(req_ready), 32'd0);
         for (int k = 0; k < d_rsp; k++) begin
            @(negedge clk);
            chk(done == 1'b0, "R8 done waits for response", 32'(done), 32'd0);
         end
         tlb_rsp_valid = 1'b1; tlb_rsp_paddr = r_pa; tlb_rsp_perm = r_pm; tlb_rsp_miss = r_ms;
         @(negedge clk);
         tlb_rsp_valid = 1'b0; tlb_rsp_paddr = ~r_pa; tlb_rsp_perm = ~r_pm; tlb_rsp_miss = ~r_ms;
         chk(done == 1'b1, "R8 done after response", 32'(done), 32'd1);
         chk(paddr == r_pa, "R6 TLB address returned", paddr, r_pa);
         chk(perm == r_pm, "R6 TLB permissions returned", 32'(perm), 32'(r_pm));
         chk(miss == r_ms, "R6 TLB miss returned", 32'(miss), 32'(r_ms));
      end
   endtask

   task automatic gap();
      @(negedge clk);
      chk(done == 1'b0, "R7 done is a single pulse", 32'(done), 32'd0);
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog actual=expired expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] lo_k, hi_k;
      void'($urandom(32'd20240611));
      lo_k = 32'h7654_3210 ^ 32'h9999_9999;
      hi_k = 32'hFEDC_BA98 ^ 32'h3333_3333;
      repeat (3) @(negedge clk);
      chk(done == 1'b0, "R1 reset done", 32'(done), 32'd0);
      chk(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'd1);
      chk(tlb_req_valid == 1'b0, "R1 reset lookup idle", 32'(tlb_req_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 1'b0 && req_ready == 1'b1, "R1 idle after reset", 32'(done), 32'd0);

      // R2: disabled overrides a full mask, privileged and user
      run(32'h3ABC_DEF0, 1'b0, 32'hFFFF_FFF3, 32'hFFFF, lo_k, hi_k, 0, 0, 0, 0, 0);
      run(32'hF000_0001, 1'b1, 32'h0, 32'hFFFF, lo_k, hi_k, 0, 0, 0, 0, 0);
      gap();
      // R2 enable via bit 2 alone, then bit 3 alone; R4 low and high banks
      run(32'h0123_4567, 1'b0, 32'h4, 32'h0001, lo_k, hi_k, 0, 0, 0, 0, 0);
      run(32'h7FFF_FFFF, 1'b0, 32'h8, 32'h0080, lo_k, hi_k, 0, 0, 0, 0, 0);
      run(32'h8000_0000, 1'b0, 32'h8, 32'h0100, lo_k, hi_k, 0, 0, 0, 0, 0);
      run(32'hFFFF_FFFF, 1'b0, 32'hC, 32'h8000, lo_k, hi_k, 0, 0, 0, 0, 0);
      // R3: user access to a mapped segment goes to the TLB
      run(32'hF123_0000, 1'b1, 32'hC, 32'hFFFF, lo_k, hi_k, 2, 1, 32'h1234_5000, 3'b101, 1'b0);
      // R3: privileged access to an unmapped segment goes to the TLB, miss reply
      run(32'h5000_2000, 1'b0, 32'h4, 32'hFFDF, lo_k, hi_k, 0, 0, 32'hDEAD_B000, 3'b000, 1'b1);
      // R7: segment result right after a page result, then a gap
      run(32'h9ABC_0000, 1'b0, 32'h4, 32'h0200, lo_k, hi_k, 0, 0, 0, 0, 0);
      gap();

      for (int n = 0; n < 400; n++) begin
         logic [31:0] va, g, m, lo, hi;
         logic usr;
         va = $urandom; usr = 1'($urandom);
         g = $urandom; if ($urandom % 4 == 0) g = g & 32'hFFFF_FFF3;
         m = $urandom; lo = $urandom; hi = $urandom;
         run(va, usr, g, m, lo, hi, int'($urandom % 4), int'($urandom % 4),
             $urandom, 3'($urandom), 1'($urandom));
         if ($urandom % 3 == 0) gap();
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule